// File: doc/BRIEF.md
# Flag-producing integer ALU

This block is the execute stage of a small 32-bit processor. A caller pulses `start` with an 8-bit operation code and two operands. It gets back a result and three condition flags: V for overflow, N for negative and Z for zero. The second operand is either a register value or an 8-bit immediate taken from the instruction, and the opcode chooses which one is used.

Add, subtract and the bitwise operations finish in one cycle. Multiply and divide run on magnitudes, one bit per cycle. Add and subtract wrap around on overflow and report it in V. Multiply and divide clamp an out-of-range answer to the largest or smallest value that fits, and also report it in V.

The unit holds `busy` high while it iterates and pulses `done` for one cycle when the result and flags become valid. Both stay in place until the next accepted operation.

Top module: `int_alu`

## Requirements
- R1: Opcodes 0x00 (add) and 0x01 (subtract) return the two's-complement result truncated to WIDTH bits, and set V exactly when the signed result does not fit in WIDTH bits.
- R2: Opcodes 0x04 (A AND B), 0x05 (A OR B), 0x06 (A XOR B) and 0x07 (A AND NOT B) return the bitwise result and always clear V.
- R3: After every completed operation, N equals the top bit of the result and Z is 1 exactly when the result is zero.
- R4: Opcode 0x02 (multiply) returns the signed product. A product above the largest value returns the largest value, a product below the smallest value returns the smallest value, and both cases set V.
- R5: Opcode 0x03 (divide) returns the signed quotient truncated toward zero. Dividing the most negative value by -1 returns the largest value and sets V. Dividing by zero sets V and returns the smallest value for a negative dividend, or the largest value otherwise.
- R6: Opcodes 0x10 to 0x13 perform add, subtract, multiply and divide with the second operand taken as the 8-bit `imm8` input, sign-extended to WIDTH bits. `b_reg` is ignored for these opcodes.
- R7: For a single-cycle operation, `done` is high in the cycle after the start cycle. For multiply or divide, `done` is high WIDTH+1 cycles after the start cycle, and `busy` is high from the cycle after start until `done`.
- R8: A `start` pulse while `busy` is high is ignored. The operation in progress completes with its own result.
- R9: Any other opcode completes in one cycle with result 0 and V cleared.
- R10: During and after reset, `busy` and `done` are 0, the result is 0, V and N are 0 and Z is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation, accepted when not busy |
| opcode | input | 8 | Operation code |
| a | input | WIDTH | First operand |
| b_reg | input | WIDTH | Second operand for register forms |
| imm8 | input | 8 | Immediate for quick forms, sign-extended |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle pulse: result and flags valid |
| result | output | WIDTH | Result of the last completed operation |
| flag_v | output | 1 | Overflow or saturation |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |

## Verification
The hardest cases to reach are the saturation boundaries of the iterative units: a product that lands exactly on the most negative value, products one step past either limit, the most negative dividend over -1, and a zero divisor with each dividend sign. An instance with WIDTH of 8 makes these reachable. The bench crosses 32 operand values, which include 0, ±1, 127, -128 and -127, against each other for multiply and divide. It also sweeps the first operand fully for the one-cycle operations. A 32-bit instance then checks the immediate sign extension, the 33-cycle latency and the full-width limits with directed values.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b_reg,
  input  logic [7:0]       imm8,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             flag_v,
  output logic             flag_n,
  output logic             flag_z
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);
  localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [2*WIDTH-1:0] HALF = (2*WIDTH)'(1) << (WIDTH - 1);

  logic             quick, valid, iter_op;
  logic [2:0]       fn;
  logic [WIDTH-1:0] bimm, bop, ma, mb;

  assign quick   = opcode[4];
  assign fn      = opcode[2:0];
  assign valid   = (opcode[7:5] == 3'b000) &&
                   (quick ? (opcode[3:2] == 2'b00) : (opcode[3] == 1'b0));
  assign iter_op = valid && !fn[2] && fn[1];

  generate
    if (WIDTH > 8) begin : g_sx
      assign bimm = {{(WIDTH-8){imm8[7]}}, imm8};
    end else begin : g_tr
      assign bimm = imm8[WIDTH-1:0];
    end
  endgenerate

  assign bop = quick ? bimm : b_reg;
  assign ma  = a[WIDTH-1]   ? -a   : a;
  assign mb  = bop[WIDTH-1] ? -bop : bop;

  logic [WIDTH:0]   wide;
  logic [WIDTH-1:0] q_res;
  logic             q_v;

  always_comb begin
    wide  = '0;
    q_res = '0;
    q_v   = 1'b0;
    if (valid) begin
      case (fn)
        3'd0: begin
          wide  = {a[WIDTH-1], a} + {bop[WIDTH-1], bop};
          q_res = wide[WIDTH-1:0];
          q_v   = wide[WIDTH] != wide[WIDTH-1];
        end
        3'd1: begin
          wide  = {a[WIDTH-1], a} - {bop[WIDTH-1], bop};
          q_res = wide[WIDTH-1:0];
          q_v   = wide[WIDTH] != wide[WIDTH-1];
        end
        3'd4: q_res = a & bop;
        3'd5: q_res = a | bop;
        3'd6: q_res = a ^ bop;
        3'd7: q_res = a & ~bop;
        default: q_res = '0;
      endcase
    end
  end

  logic [2*WIDTH:0] acc, acc_n, shl;
  logic [WIDTH:0]   sum, diff;
  logic [WIDTH-1:0] m;
  logic [CW-1:0]    cnt;
  logic             is_div, neg, a_neg, b_zero;

  assign sum  = acc[2*WIDTH:WIDTH] + (acc[0] ? {1'b0, m} : '0);
  assign shl  = acc << 1;
  assign diff = shl[2*WIDTH:WIDTH] - {1'b0, m};

  always_comb begin
    if (!is_div)
      acc_n = {1'b0, sum, acc[WIDTH-1:1]};
    else if (shl[2*WIDTH:WIDTH] >= {1'b0, m})
      acc_n = {diff, shl[WIDTH-1:1], 1'b1};
    else
      acc_n = {shl[2*WIDTH:1], 1'b0};
  end

  logic [2*WIDTH-1:0] prod;
  logic [WIDTH-1:0]   quo, f_res;
  logic               f_v;

  assign prod = acc_n[2*WIDTH-1:0];
  assign quo  = acc_n[WIDTH-1:0];

  always_comb begin
    f_v   = 1'b0;
    f_res = '0;
    if (!is_div) begin
      if (neg && prod > HALF) begin
        f_v = 1'b1; f_res = MINV;
      end else if (!neg && prod >= HALF) begin
        f_v = 1'b1; f_res = MAXV;
      end else
        f_res = neg ? -prod[WIDTH-1:0] : prod[WIDTH-1:0];
    end else if (b_zero) begin
      f_v = 1'b1; f_res = a_neg ? MINV : MAXV;
    end else if (!neg && quo[WIDTH-1]) begin
      f_v = 1'b1; f_res = MAXV;
    end else
      f_res = neg ? -quo : quo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      flag_v <= 1'b0;
      cnt    <= '0;
      acc    <= '0;
      m      <= '0;
      is_div <= 1'b0;
      neg    <= 1'b0;
      a_neg  <= 1'b0;
      b_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        acc <= acc_n;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          result <= f_res;
          flag_v <= f_v;
        end
      end else if (start) begin
        if (iter_op) begin
          busy   <= 1'b1;
          cnt    <= '0;
          is_div <= fn[0];
          neg    <= a[WIDTH-1] ^ bop[WIDTH-1];
          a_neg  <= a[WIDTH-1];
          b_zero <= (bop == '0);
          m      <= fn[0] ? mb : ma;
          acc    <= {{(WIDTH+1){1'b0}}, fn[0] ? ma : mb};
        end else begin
          done   <= 1'b1;
          result <= q_res;
          flag_v <= q_v;
        end
      end
    end
  end

  assign flag_n = result[WIDTH-1];
  assign flag_z = (result == '0);

  a_r7_busy_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !iter_op) |=> (done && !busy));
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != LAST) |=> (busy && !done));
  a_r2_logic_no_v: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && valid && !quick && fn[2]) |=> !flag_v);
  a_r4_saturated: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_v && $past(busy)) |-> (result == MAXV || result == MINV));
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st8 = 1'b0, st32 = 1'b0;
  logic [7:0] op = 8'h00, imm = 8'h00;
  logic [31:0] av = '0, bv = '0;
  logic busy8, done8, v8, n8, z8, busy32, done32, v32, n32, z32;
  logic [7:0] res8;
  logic [31:0] res32;
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  int_alu #(.WIDTH(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(st8), .opcode(op), .a(av[7:0]),
    .b_reg(bv[7:0]), .imm8(imm), .busy(busy8), .done(done8), .result(res8),
    .flag_v(v8), .flag_n(n8), .flag_z(z8));

  int_alu #(.WIDTH(32)) u_dut32 (
    .clk(clk), .rst_n(rst_n), .start(st32), .opcode(op), .a(av),
    .b_reg(bv), .imm8(imm), .busy(busy32), .done(done32), .result(res32),
    .flag_v(v32), .flag_n(n32), .flag_z(z32));

  function automatic bit op_ok(logic [7:0] o);
    return (o <= 8'h07) || (o >= 8'h10 && o <= 8'h13);
  endfunction

  function automatic logic [32:0] ref_op(int w, logic [7:0] o, logic [31:0] a, logic [31:0] b);
    longint mk = (longint'(1) << w) - 1;
    longint mx = (longint'(1) << (w - 1)) - 1;
    longint mn = -(longint'(1) << (w - 1));
    longint sa, sb, r;
    logic v = 1'b0;
    sa = a[w-1] ? longint'(a) - (mk + 1) : longint'(a);
    sb = b[w-1] ? longint'(b) - (mk + 1) : longint'(b);
    r = 0;
    if (op_ok(o)) begin
      case (o[2:0])
        3'd0: begin r = sa + sb; v = (r > mx) || (r < mn); end
        3'd1: begin r = sa - sb; v = (r > mx) || (r < mn); end
        3'd2: begin
          r = sa * sb;
          if (r > mx) begin r = mx; v = 1'b1; end
          if (r < mn) begin r = mn; v = 1'b1; end
        end
        3'd3: begin
          if (sb == 0) begin v = 1'b1; r = (sa < 0) ? mn : mx; end
          else begin
            r = sa / sb;
            if (r > mx) begin r = mx; v = 1'b1; end
          end
        end
        3'd4: r = longint'(a & b);
        3'd5: r = longint'(a | b);
        3'd6: r = longint'(a ^ b);
        default: r = longint'(a & ~b);
      endcase
    end
    return {v, 32'(r & mk)};
  endfunction

  function automatic string tag_of(logic [7:0] o);
    if (!op_ok(o)) return "R9";
    if (o[4]) return "R6";
    case (o[2:0])
      3'd0, 3'd1: return "R1";
      3'd2: return "R4";
      3'd3: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic run(input bit big, input logic [7:0] o, input logic [31:0] a,
                     input logic [31:0] b, input logic [7:0] im);
    int w = big ? 32 : 8;
    int lat = 1, exp_lat;
    logic [31:0] bx, got, mk;
    logic [32:0] e;
    logic gv, gn, gz;
    mk = big ? 32'hFFFF_FFFF : 32'hFF;
    @(negedge clk);
    op = o; av = a & mk; bv = b & mk; imm = im;
    if (big) st32 = 1'b1; else st8 = 1'b1;
    @(negedge clk);
    st8 = 1'b0; st32 = 1'b0;
    while (!(big ? done32 : done8) && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    got = big ? res32 : {24'b0, res8};
    gv = big ? v32 : v8; gn = big ? n32 : n8; gz = big ? z32 : z8;
    bx = o[4] ? {{24{im[7]}}, im} & mk : b & mk;
    e = ref_op(w, o, a & mk, bx);
    exp_lat = (op_ok(o) && o[2:1] == 2'b01) ? w + 1 : 1;
    checks++;
    if (got != e[31:0] || gv != e[32]) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h imm=%h: result=%h v=%b expected result=%h v=%b",
               tag_of(o), o, a & mk, b & mk, im, got, gv, e[31:0], e[32]);
    end
    checks++;
    if (gn != e[w-1] || gz != (e[31:0] == 0)) begin
      errors++;
      $display("FAIL R3 op=%h: n=%b z=%b expected n=%b z=%b", o, gn, gz, e[w-1], e[31:0] == 0);
    end
    checks++;
    if (lat != exp_lat) begin
      errors++;
      $display("FAIL R7 op=%h width=%0d: latency %0d expected %0d", o, w, lat, exp_lat);
    end
  endtask

  function automatic logic [7:0] pick(int k);
    case (k)
      0: return 8'h00; 1: return 8'h01; 2: return 8'h02; 3: return 8'h7F;
      4: return 8'h80; 5: return 8'h81; 6: return 8'hFF; 7: return 8'hFE;
      default: return 8'((k * 53) & 255);
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run exceeded cycle limit");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] ops1 [6] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h06, 8'h07};
    logic [7:0] badops [5] = '{8'h08, 8'h14, 8'h20, 8'h1C, 8'hFF};
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (busy8 || done8 || res8 != 0 || v8 || n8 || !z8 ||
        busy32 || done32 || res32 != 0 || v32 || n32 || !z32) begin
      errors++;
      $display("FAIL R10 reset state: busy=%b done=%b res=%h v=%b n=%b z=%b expected 0 0 00 0 0 1",
               busy8, done8, res8, v8, n8, z8);
    end
    rst_n = 1'b1;

    // R1 R2 R3: one-cycle operations, full sweep of a
    for (int oi = 0; oi < 6; oi++)
      for (int ai = 0; ai < 256; ai++)
        for (int bk = 0; bk < 16; bk++)
          run(1'b0, ops1[oi], 32'(ai), 32'(pick(bk * 2)), 8'h5A);

    // R4 R5: multiply and divide cross product
    for (int ak = 0; ak < 32; ak++)
      for (int bk = 0; bk < 32; bk++) begin
        run(1'b0, 8'h02, 32'(pick(ak)), 32'(pick(bk)), 8'h00);
        run(1'b0, 8'h03, 32'(pick(ak)), 32'(pick(bk)), 8'h00);
      end

    // R6: quick forms, b_reg holds a value that must be ignored
    for (int qo = 0; qo < 4; qo++)
      for (int ak = 0; ak < 4; ak++)
        for (int im = 0; im < 256; im++)
          run(1'b0, 8'h10 + 8'(qo), 32'(pick(ak * 2 + 2)), 32'h33, 8'(im));

    // R9: unsupported opcodes
    for (int k = 0; k < 5; k++) run(1'b0, badops[k], 32'h5C, 32'h0F, 8'h11);

    // R6 R1 at full width: sign extension of the immediate
    run(1'b1, 8'h10, 32'h0000_1000, 32'hDEAD_BEEF, 8'hFF);
    run(1'b1, 8'h11, 32'h8000_0000, 32'h0, 8'h01);
    run(1'b1, 8'h12, 32'h0000_0100, 32'h0, 8'h80);
    run(1'b1, 8'h13, 32'hFFFF_FF00, 32'h7, 8'hF0);
    // R4 R5 at full width: limits and 33-cycle latency
    run(1'b1, 8'h02, 32'h0001_0000, 32'h0000_8000, 8'h00);
    run(1'b1, 8'h02, 32'hFFFF_0000, 32'h0000_8000, 8'h00);
    run(1'b1, 8'h02, 32'h0001_0000, 32'h0000_8001, 8'h00);
    run(1'b1, 8'h02, 32'h8000_0000, 32'hFFFF_FFFF, 8'h00);
    run(1'b1, 8'h03, 32'h8000_0000, 32'hFFFF_FFFF, 8'h00);
    run(1'b1, 8'h03, 32'hFFFF_FFF9, 32'h0000_0002, 8'h00);
    run(1'b1, 8'h03, 32'h8000_0001, 32'h0, 8'h00);
    run(1'b1, 8'h03, 32'h0, 32'h0, 8'h00);
    run(1'b1, 8'h07, 32'hF0F0_FFFF, 32'h00FF_0F0F, 8'h00);

    // R8: start during a multiply is ignored
    @(negedge clk);
    op = 8'h02; av = 32'h05; bv = 32'h07; st8 = 1'b1;
    @(negedge clk);
    st8 = 1'b0;
    repeat (2) @(negedge clk);
    op = 8'h00; av = 32'h01; bv = 32'h01; st8 = 1'b1;
    @(negedge clk);
    st8 = 1'b0;
    checks++;
    if (done8 || !busy8) begin
      errors++;
      $display("FAIL R8 start while busy: done=%b busy=%b expected done=0 busy=1", done8, busy8);
    end
    for (int k = 0; k < 40 && !done8; k++) @(negedge clk);
    checks++;
    if (!done8 || res8 != 8'd35 || v8) begin
      errors++;
      $display("FAIL R8 result after ignored start: done=%b res=%0d v=%b expected done=1 res=35 v=0",
               done8, res8, v8);
    end
    @(negedge clk);
    checks++;
    if (done8 || busy8) begin
      errors++;
      $display("FAIL R8 ignored start left work: done=%b busy=%b expected 0 0", done8, busy8);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule